// File: doc/BRIEF.md
# Flash Reset and Power-Down Sequencer

This block is the control logic of a flash memory device that owns the chip-select, output-enable and reset/power-down pins. It decides when the data drivers may turn on and when the part counts as deselected. It also governs what happens when the reset pin is pulled low: either a deep power-down, or an abort of a running program or erase followed by a power-down or a restart. A separate program/erase engine reports whether it is busy. In return, this block asks that engine to abort, resets the command interface to read-array mode and presets the status register.

The reset pin is asynchronous. It passes through a two-flop synchronizer and a qualification counter, so a short glitch has no effect. Chip enable, output enable and the busy flag are sampled synchronously. After every wake-up, two counters hold the read-ready and write-ready qualifiers low until the read-recovery and write-recovery delays have run out. After an abort, both delays count from the end of the abort phase. Every delay is a cycle-count parameter.

Top module: `flash_pwr_seq`

## Requirements
- R1: While the block is awake, out_drv_en is 1 one cycle after ce_n=0 and oe_n=0 are sampled. It is 0 one cycle after oe_n=1 is sampled.
- R2: When ce_n=1 is sampled with the engine idle, the next cycle shows standby=1 and out_drv_en=0 whatever oe_n is. rd_ready stays 1, so a later read has no extra latency.
- R3: When ce_n=1 while pe_busy=1, standby stays 0. It becomes 1 the cycle after pe_busy drops.
- R4: A low pulse on rp_n that lasts fewer than T_PULSE synchronized cycles is ignored: cui_reset, abort_req and sr_preset stay 0, and rd_ready stays 1.
- R5: When rp_n is held low for at least T_PULSE synchronized cycles with the engine idle, the block powers down: standby=1, out_drv_en=0, cui_reset=1, rd_ready=0 and wr_ready=0. A pulse of exactly T_PULSE cycles already causes a power-down/wake cycle.
- R6: On each wake-up, sr_preset pulses high for exactly one cycle and status_ready (status bit 7, so the preset value is 0x80) reads 1.
- R7: rd_ready rises exactly T_RD cycles after the cycle in which sr_preset is high, and wr_ready rises exactly T_WR cycles after it. Both are 0 before that.
- R8: A qualified reset while pe_busy=1 raises abort_req for exactly T_ABORT cycles, with cui_reset=1 throughout.
- R9: If rp_n is already high when the abort phase ends, sr_preset is high in the first cycle with abort_req=0. The recovery delays count from that cycle, not from the release of rp_n.
- R10: If rp_n is still low when the abort phase ends, the block enters power-down with no sr_preset pulse. It wakes only after rp_n is released.
- R11: While awake, status_ready equals the inverse of pe_busy sampled one cycle earlier.
- R12: During rst, out_drv_en, abort_req, sr_preset, rd_ready and wr_ready are 0. After rst is released with rp_n high, a wake-up sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, synchronous |
| oe_n | input | 1 | Output enable, active low, synchronous |
| rp_n | input | 1 | Reset/power-down pin, active low, asynchronous |
| pe_busy | input | 1 | Program/erase engine busy flag |
| out_drv_en | output | 1 | Data output driver enable |
| standby | output | 1 | Device deselected or powered down |
| abort_req | output | 1 | Abort request to the program/erase engine |
| cui_reset | output | 1 | Forces the command interface to read-array mode |
| sr_preset | output | 1 | One-cycle status register preset to 0x80 |
| status_ready | output | 1 | Status register bit 7, ready |
| rd_ready | output | 1 | Read-recovery delay has elapsed |
| wr_ready | output | 1 | Write-recovery delay has elapsed |

## Verification
Responses to ce_n, oe_n and pe_busy are due one clock after the edge that samples them, so the bench drives on a falling edge and checks on the next one. A change on rp_n has a variable latency through the synchronizer and the qualifier. The bench therefore does not pin a cycle count for it: it waits a bounded number of cycles for sr_preset or abort_req. From those events it then counts exactly: T_ABORT cycles of abort_req, and T_RD and T_WR cycles from the sr_preset cycle to the rising edges of rd_ready and wr_ready. Glitch immunity is checked by watching every cycle of a window after a pulse one cycle too short.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ABORT  = 2'd1,
    ST_PWRDN  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/rp_qualifier.sv
module rp_qualifier #(
  parameter int T_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rp_n,
  output logic rp_low,
  output logic rp_qual
);
  localparam int CW = $clog2(T_PULSE + 1);

  logic          sync1;
  logic [CW-1:0] cnt;

  // two-flop synchronizer, resets to "reset asserted"
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1  <= 1'b1;
      rp_low <= 1'b1;
    end else begin
      sync1  <= ~rp_n;
      rp_low <= sync1;
    end
  end

  // low-level qualification counter
  always_ff @(posedge clk) begin
    if (rst || !rp_low) begin
      cnt     <= '0;
      rp_qual <= 1'b0;
    end else begin
      if (cnt != CW'(T_PULSE - 1)) cnt <= cnt + 1'b1;
      rp_qual <= rp_qual || (cnt == CW'(T_PULSE - 1));
    end
  end

  // R4: qualification collapses as soon as the synchronized level is high
  assert_qual_drop_R4: assert property (@(posedge clk) disable iff (rst)
    !rp_low |=> !rp_qual);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import flash_pwr_pkg::*;
#(
  parameter int T_ABORT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic pe_busy,
  input  logic rp_low,
  input  logic rp_qual,
  output logic active,
  output logic pwrdn,
  output logic abort_req,
  output logic cui_reset,
  output logic wake_pulse
);
  localparam int AW = $clog2(T_ABORT + 1);
  localparam int KW = $clog2(T_ABORT + 2);

  pwr_state_e    st, nxt;
  logic [AW-1:0] acnt;
  logic          wake;

  always_comb begin
    nxt  = st;
    wake = 1'b0;
    case (st)
      ST_ACTIVE: if (rp_qual) nxt = pe_busy ? ST_ABORT : ST_PWRDN;
      ST_ABORT: begin
        if (acnt == AW'(T_ABORT - 1)) begin
          if (rp_low) nxt = ST_PWRDN;
          else begin
            nxt  = ST_ACTIVE;
            wake = 1'b1;
          end
        end
      end
      ST_PWRDN: begin
        if (!rp_low) begin
          nxt  = ST_ACTIVE;
          wake = 1'b1;
        end
      end
      default: nxt = ST_PWRDN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_PWRDN;
      acnt       <= '0;
      active     <= 1'b0;
      pwrdn      <= 1'b1;
      abort_req  <= 1'b0;
      cui_reset  <= 1'b1;
      wake_pulse <= 1'b0;
    end else begin
      st         <= nxt;
      acnt       <= (st == ST_ABORT) ? acnt + 1'b1 : '0;
      active     <= (nxt == ST_ACTIVE);
      pwrdn      <= (nxt == ST_PWRDN);
      abort_req  <= (nxt == ST_ABORT);
      cui_reset  <= (nxt != ST_ACTIVE);
      wake_pulse <= wake;
    end
  end

  // independent length counter for the abort phase
  logic [KW-1:0] chk_len;
  always_ff @(posedge clk) begin
    if (rst) chk_len <= '0;
    else     chk_len <= abort_req ? chk_len + 1'b1 : '0;
  end

  // R8: abort phase lasts exactly T_ABORT cycles
  assert_abort_len_R8: assert property (@(posedge clk) disable iff (rst)
    (!abort_req && $past(abort_req)) |-> (chk_len == KW'(T_ABORT)));
  assert_abort_bound_R8: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> (chk_len < KW'(T_ABORT)));
  // R8: command interface held in reset during the abort
  assert_abort_cui_R8: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> cui_reset);
  // R6: wake pulse is a single cycle
  assert_wake_single_R6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
endmodule

// File: rtl/recovery_timer.sv
module recovery_timer #(
  parameter int DELAY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic ready
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt   <= cnt + 1'b1;
      ready <= (cnt == CW'(DELAY - 1));
    end
  end

  // cycles since hold was released, saturating
  logic [CW:0] age;
  always_ff @(posedge clk) begin
    if (rst || hold)             age <= '0;
    else if (age != {(CW+1){1'b1}}) age <= age + 1'b1;
  end

  // R5: no readiness while held in power-down/abort
  assert_hold_clear_R5: assert property (@(posedge clk) disable iff (rst)
    hold |=> !ready);
  // R7: readiness appears exactly DELAY cycles after release
  assert_delay_exact_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (age == (CW+1)'(DELAY)));
endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq #(
  parameter int T_PULSE = 4,
  parameter int T_ABORT = 6,
  parameter int T_RD    = 5,
  parameter int T_WR    = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic rp_n,
  input  logic pe_busy,
  output logic out_drv_en,
  output logic standby,
  output logic abort_req,
  output logic cui_reset,
  output logic sr_preset,
  output logic status_ready,
  output logic rd_ready,
  output logic wr_ready
);
  localparam int NTMR = 2;

  logic            rp_low, rp_qual;
  logic            active, pwrdn;
  logic [NTMR-1:0] ready_vec;

  rp_qualifier #(.T_PULSE(T_PULSE)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .rp_n    (rp_n),
    .rp_low  (rp_low),
    .rp_qual (rp_qual)
  );

  pwr_fsm #(.T_ABORT(T_ABORT)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pe_busy    (pe_busy),
    .rp_low     (rp_low),
    .rp_qual    (rp_qual),
    .active     (active),
    .pwrdn      (pwrdn),
    .abort_req  (abort_req),
    .cui_reset  (cui_reset),
    .wake_pulse (sr_preset)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam int DLY = (g == 0) ? T_RD : T_WR;
    recovery_timer #(.DELAY(DLY)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .hold  (!active),
      .ready (ready_vec[g])
    );
  end

  assign rd_ready = ready_vec[0];
  assign wr_ready = ready_vec[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_drv_en   <= 1'b0;
      standby      <= 1'b0;
      status_ready <= 1'b0;
    end else begin
      out_drv_en   <= active && !ce_n && !oe_n;
      standby      <= pwrdn || (active && ce_n && !pe_busy);
      status_ready <= !pe_busy || pwrdn;
    end
  end

  // R1: output enable high tri-states the drivers
  assert_oe_hiz_R1: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !out_drv_en);
  // R2: deselect tri-states the drivers regardless of oe_n
  assert_ce_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !out_drv_en);
  // R3: no standby while an operation runs
  assert_busy_active_R3: assert property (@(posedge clk) disable iff (rst)
    (active && pe_busy) |=> !standby);
  // R7: preset cycle precedes any read readiness
  assert_preset_first_R7: assert property (@(posedge clk) disable iff (rst)
    sr_preset |-> (!rd_ready && !wr_ready));
  // R10: no drivers while powered down
  assert_pwrdn_hiz_R10: assert property (@(posedge clk) disable iff (rst)
    pwrdn |=> !out_drv_en);
endmodule

// File: tb/flash_pwr_seq_tb_top.sv
module flash_pwr_seq_tb_top;
  localparam int T_PULSE = 4;
  localparam int T_ABORT = 6;
  localparam int T_RD    = 5;
  localparam int T_WR    = 9;

  logic clk = 1'b0;
  logic rst, ce_n, oe_n, rp_n, pe_busy;
  logic out_drv_en, standby, abort_req, cui_reset, sr_preset;
  logic status_ready, rd_ready, wr_ready;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  flash_pwr_seq #(.T_PULSE(T_PULSE), .T_ABORT(T_ABORT), .T_RD(T_RD), .T_WR(T_WR)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .rp_n(rp_n), .pe_busy(pe_busy),
    .out_drv_en(out_drv_en), .standby(standby), .abort_req(abort_req),
    .cui_reset(cui_reset), .sr_preset(sr_preset), .status_ready(status_ready),
    .rd_ready(rd_ready), .wr_ready(wr_ready)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_preset(input string req);
    int n = 0;
    while (!sr_preset && n < 100) begin
      tick();
      n++;
    end
    chk({req, " sr_preset seen"}, int'(sr_preset), 1);
  endtask

  // current sample has sr_preset=1
  task automatic measure_recovery(input string tag);
    int rd_at = -1;
    int wr_at = -1;
    chk({tag, " R6 status_ready at preset"}, int'(status_ready), 1);
    chk({tag, " R7 rd_ready low at preset"}, int'(rd_ready), 0);
    for (int k = 1; k <= 40; k++) begin
      tick();
      if (k == 1) chk({tag, " R6 preset one cycle"}, int'(sr_preset), 0);
      if (rd_ready && rd_at < 0) rd_at = k;
      if (wr_ready && wr_at < 0) wr_at = k;
    end
    chk({tag, " R7 read delay"}, rd_at, T_RD);
    chk({tag, " R7 write delay"}, wr_at, T_WR);
  endtask

  task automatic t_reset();
    rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; rp_n = 1'b1; pe_busy = 1'b0;
    repeat (3) tick();
    chk("R12 out_drv_en in reset", int'(out_drv_en), 0);
    chk("R12 abort_req in reset", int'(abort_req), 0);
    chk("R12 sr_preset in reset", int'(sr_preset), 0);
    chk("R12 ready in reset", int'(rd_ready | wr_ready), 0);
    rst = 1'b0;
    wait_preset("R12");
    measure_recovery("R12 initial wake");
  endtask

  task automatic t_read();
    ce_n = 1'b0; oe_n = 1'b0;
    tick();
    chk("R1 drivers on", int'(out_drv_en), 1);
    oe_n = 1'b1;
    tick();
    chk("R1 drivers off oe high", int'(out_drv_en), 0);
    oe_n = 1'b0;
    tick();
    chk("R1 drivers on again", int'(out_drv_en), 1);
  endtask

  task automatic t_standby();
    ce_n = 1'b1;
    tick();
    chk("R2 standby", int'(standby), 1);
    chk("R2 drivers off", int'(out_drv_en), 0);
    chk("R2 rd_ready kept", int'(rd_ready), 1);
    ce_n = 1'b0;
    tick();
    chk("R2 drivers back", int'(out_drv_en), 1);
    chk("R2 standby cleared", int'(standby), 0);
  endtask

  task automatic t_busy_deselect();
    pe_busy = 1'b1;
    tick();
    chk("R11 status busy", int'(status_ready), 0);
    ce_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 no standby while busy", int'(standby), 0);
    end
    pe_busy = 1'b0;
    tick();
    chk("R3 standby after done", int'(standby), 1);
    chk("R11 status ready", int'(status_ready), 1);
    ce_n = 1'b0;
    tick();
  endtask

  task automatic t_glitch();
    int bad = 0;
    rp_n = 1'b0;
    repeat (T_PULSE - 1) tick();
    rp_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (cui_reset || abort_req || sr_preset || !rd_ready) bad++;
    end
    chk("R4 short pulse ignored", bad, 0);
  endtask

  task automatic t_powerdown();
    int saw_cui = 0;
    int n = 0;
    // boundary: exactly T_PULSE cycles low
    rp_n = 1'b0;
    repeat (T_PULSE) tick();
    rp_n = 1'b1;
    while (!sr_preset && n < 40) begin
      if (cui_reset) saw_cui = 1;
      tick();
      n++;
    end
    chk("R5 min pulse acts", saw_cui, 1);
    chk("R5 min pulse wake", int'(sr_preset), 1);
    measure_recovery("R5 min pulse");
    // long hold
    rp_n = 1'b0;
    repeat (14) tick();
    chk("R5 standby", int'(standby), 1);
    chk("R5 drivers off", int'(out_drv_en), 0);
    chk("R5 cui_reset", int'(cui_reset), 1);
    chk("R5 not ready", int'(rd_ready | wr_ready), 0);
    rp_n = 1'b1;
    wait_preset("R5 release");
    measure_recovery("R5 release");
  endtask

  task automatic t_abort_release();
    int n = 0;
    int len = 1;
    pe_busy = 1'b1;
    tick();
    rp_n = 1'b0;
    while (!abort_req && n < 40) begin
      tick();
      n++;
    end
    chk("R8 abort raised", int'(abort_req), 1);
    chk("R8 cui_reset in abort", int'(cui_reset), 1);
    rp_n = 1'b1;
    pe_busy = 1'b0;
    tick();
    while (abort_req && len < 50) begin
      len++;
      tick();
    end
    chk("R8 abort length", len, T_ABORT);
    chk("R9 preset at abort end", int'(sr_preset), 1);
    measure_recovery("R9 after abort");
  endtask

  task automatic t_abort_hold();
    int n = 0;
    int len = 1;
    pe_busy = 1'b1;
    tick();
    rp_n = 1'b0;
    while (!abort_req && n < 40) begin
      tick();
      n++;
    end
    pe_busy = 1'b0;
    tick();
    while (abort_req && len < 50) begin
      len++;
      tick();
    end
    chk("R8 abort length held", len, T_ABORT);
    chk("R10 no preset", int'(sr_preset), 0);
    repeat (2) tick();
    chk("R10 standby", int'(standby), 1);
    chk("R10 cui_reset", int'(cui_reset), 1);
    chk("R10 not ready", int'(rd_ready), 0);
    rp_n = 1'b1;
    wait_preset("R10 release");
    measure_recovery("R10 release");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read();
    t_standby();
    t_busy_deselect();
    t_glitch();
    t_powerdown();
    t_read();
    t_abort_release();
    t_abort_hold();
    t_read();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule